// File: doc/BRIEF.md
# Serial SAR converter interface logic

This block is the digital control and output side of a 12-bit sampling converter. A host starts a conversion by pulling an active-low start strobe low. The block then pulls an active-low busy flag low for a fixed number of system clock cycles. When the conversion ends it takes a two's-complement result from a parallel port, which stands in for the analog core. The result is sent MSB first on a serial data pin.

The serial clock can come from either side. In internal-clock mode the block makes its own serial clock, and the result of one conversion is sent during the next one. In external-clock mode the host supplies the serial clock. That clock is synchronised into the system clock domain and edge-detected, and each rising edge presents the next bit. A new result enters the output register only when the synchronised host clock is low, or chip select is high, at the cycle where busy returns high; otherwise the register keeps its old contents. Chip select gates the serial outputs but has no say over starting a conversion.

Top module: `sar_serial_if`

## Requirements
- R1: A conversion starts at the first clock edge that samples `conv_ni` low after having sampled it high, with no conversion running; `busy_no` goes low at that same edge.
- R2: `busy_no` stays low for exactly `CONV_CYCLES` clock cycles, then returns high. `result_i` is captured at the edge where it returns high.
- R3: While `busy_no` is low, falling edges on `conv_ni` are ignored: the busy time is not extended and no further conversion is queued.
- R4: `cs_ni` has no effect on starting a conversion; a falling `conv_ni` edge starts one with `cs_ni` high.
- R5: Internal mode (`ext_mode_i`=0). The result captured at the end of conversion n is sent during conversion n+1, starting at the edge where busy falls. Bits go MSB first, each held for 2*`SCLK_HALF` cycles. `sclk_o` is low for the first `SCLK_HALF` cycles of each bit and high for the rest. The word is 12 bits, passed through unchanged as two's complement.
- R6: Internal mode: outside a transfer, `sdata_o` and `sclk_o` are low.
- R7: Internal mode with `cs_ni` high for a whole conversion: the transfer still runs internally with the outputs disabled, so that word is never seen.
- R8: External mode (`ext_mode_i`=1). At the edge where busy returns high, the output register loads `result_i` if the synchronised `sclk_i` is low or `cs_ni` is high. Otherwise it keeps its old contents and bit position.
- R9: External mode. After a load, `sdata_o` is low. The first rising edge of `sclk_i` presents the MSB, and each later rising edge presents the next bit. From the 13th rising edge on, `sdata_o` is low. `sdata_o` responds at the third clock edge after `sclk_i` changes.
- R10: `out_en_o` equals the inverse of `cs_ni` at all times. While `cs_ni` is high, `sdata_o` and `sclk_o` are held low (disabled).
- R11: In external mode `sclk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_ni | input | 1 | Active-low conversion start strobe |
| ext_mode_i | input | 1 | 0: internal serial clock, 1: host serial clock; constant while busy |
| cs_ni | input | 1 | Active-low chip select for the serial outputs |
| sclk_i | input | 1 | Host serial clock (external mode) |
| result_i | input | RES_W | Two's-complement result from the converter core |
| busy_no | output | 1 | Active-low busy flag |
| sdata_o | output | 1 | Serial data, MSB first |
| sclk_o | output | 1 | Generated serial clock (internal mode) |
| out_en_o | output | 1 | High when the serial outputs are driven |

## Verification
Busy falls at the edge that samples the start strobe low. It rises `CONV_CYCLES` edges later, and the internal-mode bits follow busy's fall with no further delay. In external mode a host clock change shows up on `sdata_o` three edges later: two synchroniser stages and the edge register. The bench steps a behavioural model at every rising edge that carries exactly these delays. It compares busy, data, clock and enable at every falling edge, so each result is checked in the cycle it is due and in every cycle around it.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;
  localparam int unsigned RES_W = 12;
  typedef enum logic {CLK_INT = 1'b0, CLK_EXT = 1'b1} clk_mode_e;
endpackage

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int unsigned CONV_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_ni,
  output logic start_o,
  output logic done_o,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CONV_CYCLES + 1);

  logic          conv_q;
  logic [CW-1:0] cnt_q;

  assign busy_o  = (cnt_q != '0);
  assign start_o = conv_q & ~conv_ni & ~busy_o;
  assign done_o  = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      conv_q <= conv_ni;
      if (start_o)     cnt_q <= CW'(CONV_CYCLES);
      else if (busy_o) cnt_q <= cnt_q - CW'(1);
    end
  end

  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_q && !conv_ni && !busy_o) |=> busy_o);
  assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != CW'(1)) |=> busy_o);
  assert_busy_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_conv_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && conv_q && !conv_ni && cnt_q != CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/sar_sclk_sync.sv
module sar_sclk_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= sclk_i;
      prev_q    <= sync_q[SYNC_STAGES-1];
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~prev_q;

  assert_rise_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sar_out_shifter.sv
module sar_out_shifter
  import sar_if_pkg::*;
#(
  parameter int unsigned RES_W      = 12,
  parameter int unsigned SCLK_HALF  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             cs_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             sclk_lvl_i,
  input  logic             sclk_rise_i,
  output logic             data_o,
  output logic             sclk_o
);
  localparam int unsigned PER = 2 * SCLK_HALF;
  localparam int unsigned PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int unsigned BW  = $clog2(RES_W);
  localparam int unsigned EW  = $clog2(RES_W + 2);

  clk_mode_e        mode;
  logic [RES_W-1:0] work_q, shreg_q;
  logic             int_act_q;
  logic [PW-1:0]    ph_q;
  logic [BW-1:0]    bit_q;
  logic [EW-1:0]    ecnt_q;
  logic             load_ext, ext_show;

  assign mode     = clk_mode_e'(ext_mode_i);
  // host clock must be idle (or outputs deselected) when busy rises
  assign load_ext = done_i & (mode == CLK_EXT) & (~sclk_lvl_i | cs_ni);
  assign ext_show = (ecnt_q != '0) && (ecnt_q <= EW'(RES_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q    <= '0;
      shreg_q   <= '0;
      int_act_q <= 1'b0;
      ph_q      <= '0;
      bit_q     <= '0;
      ecnt_q    <= '0;
    end else begin
      if (done_i) work_q <= result_i;
      if (start_i && mode == CLK_INT) begin
        shreg_q   <= work_q;
        int_act_q <= 1'b1;
        ph_q      <= '0;
        bit_q     <= '0;
      end else if (int_act_q) begin
        if (ph_q == PW'(PER - 1)) begin
          ph_q    <= '0;
          shreg_q <= shreg_q << 1;
          if (bit_q == BW'(RES_W - 1)) int_act_q <= 1'b0;
          else                         bit_q     <= bit_q + BW'(1);
        end else begin
          ph_q <= ph_q + PW'(1);
        end
      end else if (load_ext) begin
        shreg_q <= result_i;
        ecnt_q  <= '0;
      end else if (mode == CLK_EXT && sclk_rise_i && ecnt_q != EW'(RES_W + 1)) begin
        ecnt_q <= ecnt_q + EW'(1);
        if (ecnt_q != '0) shreg_q <= shreg_q << 1;
      end
    end
  end

  always_comb begin
    if (mode == CLK_EXT) begin
      data_o = ext_show & shreg_q[RES_W-1];
      sclk_o = 1'b0;
    end else begin
      data_o = int_act_q & shreg_q[RES_W-1];
      sclk_o = int_act_q & (ph_q >= PW'(SCLK_HALF));
    end
  end

  assert_int_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_act_q) |-> ($past(bit_q) == BW'(RES_W - 1) && $past(ph_q) == PW'(PER - 1)));
  assert_ext_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ext |=> (shreg_q == $past(result_i) && ecnt_q == '0));
  assert_ext_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && mode == CLK_EXT && sclk_lvl_i && !cs_ni && !sclk_rise_i)
      |=> (shreg_q == $past(shreg_q) && ecnt_q == $past(ecnt_q)));
  assert_ext_tail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CLK_EXT && ecnt_q == EW'(RES_W + 1)) |=> (ecnt_q == EW'(RES_W + 1) || ecnt_q == '0));
endmodule

// File: rtl/sar_serial_if.sv
module sar_serial_if
  import sar_if_pkg::*;
#(
  parameter int unsigned RES_W       = sar_if_pkg::RES_W,
  parameter int unsigned CONV_CYCLES = 64,
  parameter int unsigned SCLK_HALF   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_ni,
  input  logic             ext_mode_i,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic [RES_W-1:0] result_i,
  output logic             busy_no,
  output logic             sdata_o,
  output logic             sclk_o,
  output logic             out_en_o
);
  logic start, done, busy, lvl, rise, data_raw, sclk_raw;

  sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i, .rst_ni, .conv_ni,
    .start_o(start), .done_o(done), .busy_o(busy)
  );

  sar_sclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i,
    .lvl_o(lvl), .rise_o(rise)
  );

  sar_out_shifter #(.RES_W(RES_W), .SCLK_HALF(SCLK_HALF)) u_shift (
    .clk_i, .rst_ni, .ext_mode_i, .cs_ni,
    .start_i(start), .done_i(done), .result_i,
    .sclk_lvl_i(lvl), .sclk_rise_i(rise),
    .data_o(data_raw), .sclk_o(sclk_raw)
  );

  assign busy_no  = ~busy;
  assign out_en_o = ~cs_ni;
  assign sdata_o  = ~cs_ni & data_raw;
  assign sclk_o   = ~cs_ni & sclk_raw;

  assert_ext_sclk_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mode_i |-> !sclk_o);
  assert_start_any_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && cs_ni) |=> !busy_no);
endmodule

// File: tb/sar_serial_if_tb.sv
`timescale 1ns/1ps
module sar_serial_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int CONV = 64;
  localparam int H = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_n = 1'b1, ext = 1'b0, cs_n = 1'b0, sclk_in = 1'b0;
  logic [W-1:0] result = '0;
  logic busy_n, sdata, sclk, oen;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  sar_serial_if #(.RES_W(W), .CONV_CYCLES(CONV), .SCLK_HALF(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_ni(conv_n), .ext_mode_i(ext), .cs_ni(cs_n),
    .sclk_i(sclk_in), .result_i(result), .busy_no(busy_n), .sdata_o(sdata),
    .sclk_o(sclk), .out_en_o(oen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_cnt = 0, m_tk = -1, m_ecnt = 0;
  logic m_cprev = 1'b1;
  logic [W-1:0] m_work = '0, m_iword = '0, m_eword = '0;
  logic [2:0] hist = '0;
  logic fall, endc, rise, started = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_tk = -1; m_ecnt = 0; m_cprev = 1'b1;
      m_work = '0; m_iword = '0; m_eword = '0; hist = '0;
    end else begin
      started = 1'b1;
      fall = m_cprev && !conv_n;
      endc = (m_cnt == 1);
      rise = hist[1] && !hist[2];
      if (m_tk >= 0) m_tk = (m_tk + 1 == W * 2 * H) ? -1 : m_tk + 1;
      if (ext && rise && m_ecnt < W + 1) m_ecnt++;
      if (endc && ext && (!hist[1] || cs_n)) begin m_eword = result; m_ecnt = 0; end
      if (fall && m_cnt == 0) begin
        m_cnt = CONV;
        if (!ext) begin m_iword = m_work; m_tk = 0; end
      end else if (m_cnt > 0) m_cnt--;
      if (endc) m_work = result;
      hist = {hist[1:0], sclk_in};
      m_cprev = conv_n;
    end
  end

  task automatic chk(string tag, string name, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: got %0b expected %0b at cycle %0d", tag, cur_req, name, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    logic ed, es;
    if (started || !rst_n) begin
      if (ext) begin
        ed = (m_ecnt >= 1 && m_ecnt <= W) ? m_eword[W - m_ecnt] : 1'b0;
        es = 1'b0;
      end else begin
        ed = (m_tk >= 0) ? m_iword[W - 1 - m_tk / (2 * H)] : 1'b0;
        es = (m_tk >= 0) && ((m_tk % (2 * H)) >= H);
      end
      chk("R2", "busy_no", busy_n, m_cnt == 0);
      chk("R10", "out_en_o", oen, !cs_n);
      chk(ext ? "R9" : "R5", "sdata_o", sdata, ed & !cs_n);
      chk(ext ? "R11" : "R6", "sclk_o", sclk, es & !cs_n);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic conv_pulse();
    conv_n = 1'b0; tick(3); conv_n = 1'b1;
  endtask

  task automatic host_clocks(int n);
    for (int i = 0; i < n; i++) begin
      sclk_in = 1'b1; tick(5); sclk_in = 1'b0; tick(5);
    end
  endtask

  initial begin
    cur_req = "R10";
    tick(3); rst_n = 1'b1; tick(2);
    // internal mode, several words including negative codes
    cur_req = "R5";
    result = 12'h5A3; conv_pulse(); tick(CONV + 4);
    result = 12'hF00; conv_pulse(); tick(CONV + 4);
    result = 12'h801; conv_pulse(); tick(CONV + 4);
    result = 12'h7FF; conv_pulse(); tick(CONV + 4);
    // start strobes during busy
    cur_req = "R3";
    result = 12'h0AA; conv_pulse(); tick(10); conv_pulse(); tick(20); conv_pulse(); tick(CONV);
    // chip select high at start, then for whole conversion
    cur_req = "R4";
    cs_n = 1'b1; result = 12'h3C3; conv_pulse(); tick(CONV + 4);
    cur_req = "R7";
    result = 12'h123; conv_pulse(); tick(CONV + 4);
    cs_n = 1'b0; result = 12'h456; conv_pulse(); tick(CONV + 4);
    // external clock mode
    cur_req = "R9";
    ext = 1'b1; tick(2);
    result = 12'h3C5; conv_pulse(); tick(CONV + 4);
    host_clocks(14);
    cur_req = "R8";
    result = 12'hA5C; conv_pulse(); tick(CONV + 4);
    host_clocks(5);
    sclk_in = 1'b1; tick(4);
    result = 12'h0F0; conv_pulse(); tick(CONV + 4);
    sclk_in = 1'b0; tick(5);
    host_clocks(9);
    sclk_in = 1'b1; cs_n = 1'b1; tick(4);
    result = 12'hC3A; conv_pulse(); tick(CONV + 4);
    sclk_in = 1'b0; cs_n = 1'b0; tick(5);
    host_clocks(13);
    cur_req = "R11";
    result = 12'h999; conv_pulse(); tick(10); host_clocks(3); tick(CONV);
    host_clocks(13);
    tick(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog (%s): got timeout expected completion", cur_req);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule